// File: doc/BRIEF.md
# Data Space Address Decoder

This block sits between the load/store unit of a small 8-bit microcontroller core and the storage behind it. Each cycle it takes a 16-bit data-space address with read and write strobes, works out which of five targets owns that address, and drives a one-hot select, a per-target write enable and a zero-based local offset for the chosen target. The five targets are the working register file, the standard I/O registers, the extended I/O registers, the on-chip SRAM and an optional off-chip memory port. Read data from the five targets is merged back into one byte through a select-driven multiplexer.

Instructions that use the short I/O address form mark their access with a flag. The decoder then lifts the 6-bit I/O address into the data space by adding the register-file size, so both forms of access reach the same physical register. An I/O-form address that falls outside the standard I/O window reaches nothing. Low I/O addresses that support single-bit set, clear and test are flagged on a separate output.

Accesses to the off-chip port take one extra cycle. The decoder raises a wait request on the first cycle of every such access, and the core holds its address and strobes for one more cycle. When the off-chip port is switched off, the address range above the on-chip SRAM reads as zero and ignores writes.

Top module: `dspace_decoder`

## Requirements
- R1: A memory access (rd_req or wr_req high, io_instr low) to 0x0000..0x001F sets sel bit 0 and puts the address minus 0x0000 on rf_idx.
- R2: A memory access to 0x0020..0x005F sets sel bit 1 with sio_idx = address − 0x0020.
- R3: A memory access to 0x0060..0x00FF sets sel bit 2 with xio_idx = address − 0x0060 (0..159).
- R4: A memory access to 0x0100..0x10FF sets sel bit 3 with sram_off = address − 0x0100.
- R5: With xmem_en high, an access to 0x1100..0xFFFF sets sel bit 4 and passes the full address on xmem_addr.
- R6: With xmem_en low, an access to 0x1100..0xFFFF sets no sel bit and no wr_en bit, rdata is 0x00 and wait_req stays low.
- R7: With io_instr high, an addr_in of 0x00..0x3F is treated as data address addr_in + 0x20 (so it reaches standard I/O); any larger addr_in selects no target and reads 0x00.
- R8: bit_ok is high only for an active io_instr access whose addr_in is 0x00..0x1F.
- R9: wait_req is high on the first cycle of an off-chip access and low on the second; a strobe held for further cycles gives the pattern 1,0,1,0, one wait per two-cycle access.
- R10: With both strobes low, sel, wr_en, bit_ok and every offset output are zero; at most one sel bit is ever high, and wr_en equals sel while wr_req is high and is zero otherwise.
- R11: rdata carries the read-data input of the selected target while rd_req is high, and is 0x00 when no target is selected or rd_req is low; the offset output of each unselected target is zero.
- R12: After synchronous reset with rst_n low, an off-chip access presented on the first cycle after reset gets wait_req high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xmem_en | input | 1 | Off-chip memory port enabled |
| addr_in | input | 16 | Data address, or I/O address when io_instr is high |
| rd_req | input | 1 | Read strobe |
| wr_req | input | 1 | Write strobe |
| io_instr | input | 1 | Access comes from a short-form I/O instruction |
| rf_rdata | input | 8 | Read data from register file |
| sio_rdata | input | 8 | Read data from standard I/O |
| xio_rdata | input | 8 | Read data from extended I/O |
| sram_rdata | input | 8 | Read data from on-chip SRAM |
| xmem_rdata | input | 8 | Read data from off-chip port |
| sel | output | 5 | One-hot target select (0 regfile, 1 std I/O, 2 ext I/O, 3 SRAM, 4 off-chip) |
| wr_en | output | 5 | Per-target write enable |
| rf_idx | output | 5 | Register file index |
| sio_idx | output | 6 | Standard I/O index |
| xio_idx | output | 8 | Extended I/O index |
| sram_off | output | 12 | SRAM byte offset |
| xmem_addr | output | 16 | Off-chip address |
| bit_ok | output | 1 | Access targets a bit-addressable I/O register |
| wait_req | output | 1 | Stall request for the first cycle of an off-chip access |
| rdata | output | 8 | Merged read data |

## Verification
The bench probes both edges of every region (0x001F/0x0020, 0x005F/0x0060, 0x00FF/0x0100, 0x10FF/0x1100, 0xFFFF); an off-by-one compare would send an edge address to the neighbouring target or give a wrapped offset. The I/O form is driven at 0x00, 0x1F, 0x20, 0x3F and 0x40: a missing translation would land I/O accesses in the register file, and a missing range check would let 0x40 leak into extended I/O. The off-chip hole with the port disabled is read and written to catch a decoder that still selects or returns stale data. The wait request is followed over a held strobe and across a gap to catch a level-style wait that never drops or a flag that is not cleared between accesses.

// File: rtl/dsd_pkg.sv
// Package: shared constants and the target encoding for the data space
// decoder. Target order fixes the bit positions of the one-hot select.
package dsd_pkg;
    localparam int DATA_W  = 8;
    localparam int NUM_TGT = 5;

    typedef enum logic [2:0] {
        TGT_RF   = 3'd0,
        TGT_SIO  = 3'd1,
        TGT_XIO  = 3'd2,
        TGT_SRAM = 3'd3,
        TGT_XMEM = 3'd4,
        TGT_NONE = 3'd7
    } tgt_e;
endpackage

// File: rtl/dsd_io_xlate.sv
// Module: dsd_io_xlate
// Lifts a short-form I/O address into the data space by adding the
// register-file size, checks it against the standard I/O window, and flags
// the low part of that window as bit-addressable.
// Assumes: the I/O window directly follows the register file.
module dsd_io_xlate #(
    parameter int AW    = 16,
    parameter int RF_N  = 32,
    parameter int SIO_N = 64,
    parameter int BIT_N = 32
) (
    input  logic [AW-1:0] addr_in,
    input  logic          io_instr,
    output logic [AW-1:0] eff_addr,
    output logic          io_ok,
    output logic          bit_zone
);
    localparam logic [31:0] IO_LIM  = 32'(SIO_N);
    localparam logic [31:0] BIT_LIM = 32'(BIT_N);

    logic [31:0] wide_addr;

    // Purpose: widen the raw address for range comparisons.
    always_comb wide_addr = 32'(addr_in);

    // Purpose: pick the effective data address and the I/O window flags.
    always_comb begin
        io_ok    = wide_addr < IO_LIM;
        bit_zone = io_instr && (wide_addr < BIT_LIM);
        if (io_instr) eff_addr = addr_in + AW'(RF_N);
        else          eff_addr = addr_in;
    end
endmodule

// File: rtl/dsd_region_map.sv
// Module: dsd_region_map
// Classifies an effective data address into one of the five targets, or
// none. Regions are laid end to end from address zero in the order
// register file, standard I/O, extended I/O, SRAM, off-chip.
// Assumes: io_ok is only meaningful when io_instr is high.
module dsd_region_map
    import dsd_pkg::*;
#(
    parameter int AW     = 16,
    parameter int RF_N   = 32,
    parameter int SIO_N  = 64,
    parameter int XIO_N  = 160,
    parameter int SRAM_N = 4096
) (
    input  logic [AW-1:0] eff_addr,
    input  logic          io_instr,
    input  logic          io_ok,
    input  logic          xmem_en,
    output tgt_e          tgt
);
    localparam logic [31:0] SIO_BASE  = 32'(RF_N);
    localparam logic [31:0] XIO_BASE  = 32'(RF_N + SIO_N);
    localparam logic [31:0] SRAM_BASE = 32'(RF_N + SIO_N + XIO_N);
    localparam logic [31:0] XMEM_BASE = 32'(RF_N + SIO_N + XIO_N + SRAM_N);

    logic [31:0] a;

    // Purpose: widen the effective address for comparisons.
    always_comb a = 32'(eff_addr);

    // Purpose: ordered range compare, lowest region first.
    always_comb begin
        if (io_instr && !io_ok)  tgt = TGT_NONE;
        else if (a < SIO_BASE)   tgt = TGT_RF;
        else if (a < XIO_BASE)   tgt = TGT_SIO;
        else if (a < SRAM_BASE)  tgt = TGT_XIO;
        else if (a < XMEM_BASE)  tgt = TGT_SRAM;
        else if (xmem_en)        tgt = TGT_XMEM;
        else                     tgt = TGT_NONE;
    end
endmodule

// File: rtl/dsd_offsets.sv
// Module: dsd_offsets
// Produces the zero-based local offset of each target from the effective
// address. Each offset is forced to zero unless its target is selected.
// Assumes: sel is one-hot or zero.
module dsd_offsets
    import dsd_pkg::*;
#(
    parameter int AW     = 16,
    parameter int RF_N   = 32,
    parameter int SIO_N  = 64,
    parameter int XIO_N  = 160,
    parameter int SRAM_N = 4096
) (
    input  logic [AW-1:0]              eff_addr,
    input  logic [NUM_TGT-1:0]         sel,
    output logic [$clog2(RF_N)-1:0]    rf_idx,
    output logic [$clog2(SIO_N)-1:0]   sio_idx,
    output logic [$clog2(XIO_N)-1:0]   xio_idx,
    output logic [$clog2(SRAM_N)-1:0]  sram_off,
    output logic [AW-1:0]              xmem_addr
);
    localparam int RFW   = $clog2(RF_N);
    localparam int SIOW  = $clog2(SIO_N);
    localparam int XIOW  = $clog2(XIO_N);
    localparam int SRMW  = $clog2(SRAM_N);
    localparam int SIO_BASE  = RF_N;
    localparam int XIO_BASE  = RF_N + SIO_N;
    localparam int SRAM_BASE = RF_N + SIO_N + XIO_N;

    logic [AW-1:0] d_sio, d_xio, d_sram;

    // Purpose: subtract each region base from the effective address.
    always_comb begin
        d_sio  = eff_addr - AW'(SIO_BASE);
        d_xio  = eff_addr - AW'(XIO_BASE);
        d_sram = eff_addr - AW'(SRAM_BASE);
    end

    // Purpose: gate each offset with its own select bit.
    always_comb begin
        rf_idx    = sel[TGT_RF]   ? eff_addr[RFW-1:0] : '0;
        sio_idx   = sel[TGT_SIO]  ? d_sio[SIOW-1:0]   : '0;
        xio_idx   = sel[TGT_XIO]  ? d_xio[XIOW-1:0]   : '0;
        sram_off  = sel[TGT_SRAM] ? d_sram[SRMW-1:0]  : '0;
        xmem_addr = sel[TGT_XMEM] ? eff_addr          : '0;
    end
endmodule

// File: rtl/dsd_rdata_mux.sv
// Module: dsd_rdata_mux
// AND-OR merge of the targets' read data under the one-hot select.
// Assumes: sel is one-hot or zero; returns zero when nothing is read.
module dsd_rdata_mux
    import dsd_pkg::*;
#(
    parameter int NT = NUM_TGT,
    parameter int DW = DATA_W
) (
    input  logic [NT-1:0]         sel,
    input  logic                  rd,
    input  logic [NT-1:0][DW-1:0] bus,
    output logic [DW-1:0]         dout
);
    logic [NT-1:0][DW-1:0] masked;

    // Purpose: mask each lane with its select bit and the read strobe.
    for (genvar g = 0; g < NT; g++) begin : g_lane
        assign masked[g] = (sel[g] && rd) ? bus[g] : '0;
    end

    // Purpose: OR the masked lanes together.
    always_comb begin
        dout = '0;
        for (int i = 0; i < NT; i++) dout = dout | masked[i];
    end
endmodule

// File: rtl/dsd_ext_wait.sv
// Module: dsd_ext_wait
// Raises a one-cycle stall on the first cycle of each off-chip access.
// A flag remembers that the stall was given, so the second cycle of the
// access passes; a held strobe after that starts a fresh access.
// Assumes: the core holds address and strobes while wait_req is high.
module dsd_ext_wait (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_acc,
    output logic wait_req
);
    logic stalled_q;

    // Purpose: stall when an off-chip access has not yet had its wait cycle.
    always_comb wait_req = ext_acc && !stalled_q;

    // Purpose: remember that the current access has been stalled once.
    always_ff @(posedge clk) begin
        if (!rst_n) stalled_q <= 1'b0;
        else        stalled_q <= ext_acc && !stalled_q;
    end

    // R9: a stall never lasts two cycles in a row.
    a_r9_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
        wait_req |=> !wait_req);
    // R9: a newly started off-chip access is stalled.
    a_r9_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_acc) |-> wait_req);
    // R9: no stall without an off-chip access.
    a_r9_only_ext: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_acc |-> !wait_req);
endmodule

// File: rtl/dspace_decoder.sv
// Module: dspace_decoder (top)
// Decodes a 16-bit data-space access into one of five targets, lifts
// short-form I/O addresses into the data space, produces local offsets,
// per-target write enables, merged read data and an off-chip wait request.
// Assumes: the core holds address and strobes during wait_req; storage and
// off-chip pin sequencing live outside this block.
module dspace_decoder
    import dsd_pkg::*;
#(
    parameter int AW     = 16,
    parameter int RF_N   = 32,
    parameter int SIO_N  = 64,
    parameter int XIO_N  = 160,
    parameter int SRAM_N = 4096,
    parameter int BIT_N  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      xmem_en,
    input  logic [AW-1:0]             addr_in,
    input  logic                      rd_req,
    input  logic                      wr_req,
    input  logic                      io_instr,
    input  logic [DATA_W-1:0]         rf_rdata,
    input  logic [DATA_W-1:0]         sio_rdata,
    input  logic [DATA_W-1:0]         xio_rdata,
    input  logic [DATA_W-1:0]         sram_rdata,
    input  logic [DATA_W-1:0]         xmem_rdata,
    output logic [NUM_TGT-1:0]        sel,
    output logic [NUM_TGT-1:0]        wr_en,
    output logic [$clog2(RF_N)-1:0]   rf_idx,
    output logic [$clog2(SIO_N)-1:0]  sio_idx,
    output logic [$clog2(XIO_N)-1:0]  xio_idx,
    output logic [$clog2(SRAM_N)-1:0] sram_off,
    output logic [AW-1:0]             xmem_addr,
    output logic                      bit_ok,
    output logic                      wait_req,
    output logic [DATA_W-1:0]         rdata
);
    localparam int XMEM_BASE = RF_N + SIO_N + XIO_N + SRAM_N;

    logic [AW-1:0] eff_addr;
    logic          io_ok;
    logic          bit_zone;
    logic          active;
    tgt_e          tgt;
    logic [NUM_TGT-1:0][DATA_W-1:0] rd_bus;

    // Purpose: an access is in progress when either strobe is high.
    always_comb active = rd_req || wr_req;

    dsd_io_xlate #(.AW(AW), .RF_N(RF_N), .SIO_N(SIO_N), .BIT_N(BIT_N)) u_xlate (
        .addr_in  (addr_in),
        .io_instr (io_instr),
        .eff_addr (eff_addr),
        .io_ok    (io_ok),
        .bit_zone (bit_zone)
    );

    dsd_region_map #(.AW(AW), .RF_N(RF_N), .SIO_N(SIO_N), .XIO_N(XIO_N),
                     .SRAM_N(SRAM_N)) u_map (
        .eff_addr (eff_addr),
        .io_instr (io_instr),
        .io_ok    (io_ok),
        .xmem_en  (xmem_en),
        .tgt      (tgt)
    );

    // Purpose: expand the target code into select and write-enable bits.
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_sel
        assign sel[g]   = active && (tgt == tgt_e'(g));
        assign wr_en[g] = sel[g] && wr_req;
    end

    // Purpose: bit-addressable flag only for live low I/O-form accesses.
    always_comb bit_ok = active && bit_zone && io_ok;

    dsd_offsets #(.AW(AW), .RF_N(RF_N), .SIO_N(SIO_N), .XIO_N(XIO_N),
                  .SRAM_N(SRAM_N)) u_off (
        .eff_addr  (eff_addr),
        .sel       (sel),
        .rf_idx    (rf_idx),
        .sio_idx   (sio_idx),
        .xio_idx   (xio_idx),
        .sram_off  (sram_off),
        .xmem_addr (xmem_addr)
    );

    // Purpose: pack target read data in select-bit order.
    always_comb begin
        rd_bus[TGT_RF]   = rf_rdata;
        rd_bus[TGT_SIO]  = sio_rdata;
        rd_bus[TGT_XIO]  = xio_rdata;
        rd_bus[TGT_SRAM] = sram_rdata;
        rd_bus[TGT_XMEM] = xmem_rdata;
    end

    dsd_rdata_mux #(.NT(NUM_TGT), .DW(DATA_W)) u_mux (
        .sel  (sel),
        .rd   (rd_req),
        .bus  (rd_bus),
        .dout (rdata)
    );

    dsd_ext_wait u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_acc  (sel[TGT_XMEM]),
        .wait_req (wait_req)
    );

    // R10: never more than one target.
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    // R10: no target and no write without a strobe.
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (sel == '0 && wr_en == '0 && !bit_ok));
    // R10: writes only under the write strobe.
    a_r10_wr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |-> wr_en == '0);
    // R6: disabled off-chip range is a silent hole.
    a_r6_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (!xmem_en && !io_instr && 32'(addr_in) >= 32'(XMEM_BASE))
        |-> (sel == '0 && rdata == '0 && !wait_req));
    // R7: I/O-form accesses never leave the register/standard I/O area.
    a_r7_io_limit: assert property (@(posedge clk) disable iff (!rst_n)
        io_instr |-> (!sel[TGT_XIO] && !sel[TGT_SRAM] && !sel[TGT_XMEM]));
    // R8: a bit-addressable access always lands in standard I/O.
    a_r8_bit_sio: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ok |-> (sel[TGT_SIO] && io_instr));
    // R11: no read data without a read.
    a_r11_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |-> rdata == '0);
    // R5: off-chip address is passed through unchanged.
    a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
        sel[TGT_XMEM] |-> xmem_addr == addr_in);
endmodule

// File: tb/sim_dspace_decoder.sv
// Directed bench for dspace_decoder: one task per scenario.
module sim_dspace_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xmem_en = 1'b0;
    logic [15:0] addr_in = '0;
    logic        rd_req = 1'b0, wr_req = 1'b0, io_instr = 1'b0;
    logic [7:0]  rf_rdata = 8'hA1, sio_rdata = 8'hB2, xio_rdata = 8'hC3;
    logic [7:0]  sram_rdata = 8'hD4, xmem_rdata = 8'hE5;
    logic [4:0]  sel, wr_en, rf_idx;
    logic [5:0]  sio_idx;
    logic [7:0]  xio_idx, rdata;
    logic [11:0] sram_off;
    logic [15:0] xmem_addr;
    logic        bit_ok, wait_req;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dspace_decoder u0 (
        .clk(clk), .rst_n(rst_n), .xmem_en(xmem_en), .addr_in(addr_in),
        .rd_req(rd_req), .wr_req(wr_req), .io_instr(io_instr),
        .rf_rdata(rf_rdata), .sio_rdata(sio_rdata), .xio_rdata(xio_rdata),
        .sram_rdata(sram_rdata), .xmem_rdata(xmem_rdata),
        .sel(sel), .wr_en(wr_en), .rf_idx(rf_idx), .sio_idx(sio_idx),
        .xio_idx(xio_idx), .sram_off(sram_off), .xmem_addr(xmem_addr),
        .bit_ok(bit_ok), .wait_req(wait_req), .rdata(rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive a new access at the falling edge, settle, then return.
    task automatic put(logic [15:0] a, logic r, logic w, logic io);
        @(negedge clk);
        addr_in = a; rd_req = r; wr_req = w; io_instr = io;
        #1;
    endtask

    task automatic idle();
        put(16'h0000, 0, 0, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 reset sel", 32'(sel), 0);
        chk("R10 reset wr_en", 32'(wr_en), 0);
        chk("R11 reset rdata", 32'(rdata), 0);
        chk("R9 reset wait", 32'(wait_req), 0);
    endtask

    task automatic t_regfile();
        put(16'h0000, 1, 0, 0);
        chk("R1 sel lo", 32'(sel), 32'h01);
        chk("R1 idx lo", 32'(rf_idx), 0);
        chk("R11 rdata rf", 32'(rdata), 32'hA1);
        put(16'h001F, 1, 0, 0);
        chk("R1 idx hi", 32'(rf_idx), 31);
        chk("R11 others zero", 32'(sram_off), 0);
    endtask

    task automatic t_stdio();
        put(16'h0020, 1, 0, 0);
        chk("R2 sel lo", 32'(sel), 32'h02);
        chk("R2 idx lo", 32'(sio_idx), 0);
        chk("R11 rf idx unsel", 32'(rf_idx), 0);
        put(16'h005F, 0, 1, 0);
        chk("R2 idx hi", 32'(sio_idx), 63);
        chk("R10 wr_en sio", 32'(wr_en), 32'h02);
        chk("R11 rdata no read", 32'(rdata), 0);
        chk("R8 no bit on mem form", 32'(bit_ok), 0);
    endtask

    task automatic t_extio();
        put(16'h0060, 1, 0, 0);
        chk("R3 sel lo", 32'(sel), 32'h04);
        chk("R3 idx lo", 32'(xio_idx), 0);
        chk("R11 rdata xio", 32'(rdata), 32'hC3);
        put(16'h00FF, 1, 0, 0);
        chk("R3 idx hi", 32'(xio_idx), 159);
    endtask

    task automatic t_sram();
        put(16'h0100, 1, 0, 0);
        chk("R4 sel lo", 32'(sel), 32'h08);
        chk("R4 off lo", 32'(sram_off), 0);
        chk("R9 no wait sram", 32'(wait_req), 0);
        put(16'h10FF, 0, 1, 0);
        chk("R4 off hi", 32'(sram_off), 32'hFFF);
        chk("R10 wr_en sram", 32'(wr_en), 32'h08);
    endtask

    task automatic t_xmem_on();
        idle();
        xmem_en = 1'b1;
        put(16'h1100, 1, 0, 0);
        chk("R5 sel lo", 32'(sel), 32'h10);
        chk("R5 addr lo", 32'(xmem_addr), 32'h1100);
        chk("R11 rdata xmem", 32'(rdata), 32'hE5);
        chk("R9 wait first", 32'(wait_req), 1);
        @(negedge clk); #1;
        chk("R9 wait second", 32'(wait_req), 0);
        @(negedge clk); #1;
        chk("R9 held third", 32'(wait_req), 1);
        @(negedge clk); #1;
        chk("R9 held fourth", 32'(wait_req), 0);
        idle();
        chk("R9 idle no wait", 32'(wait_req), 0);
        put(16'hFFFF, 0, 1, 0);
        chk("R5 addr hi", 32'(xmem_addr), 32'hFFFF);
        chk("R10 wr_en xmem", 32'(wr_en), 32'h10);
        chk("R9 wait after gap", 32'(wait_req), 1);
        idle();
    endtask

    task automatic t_xmem_off();
        xmem_en = 1'b0;
        put(16'h1100, 1, 0, 0);
        chk("R6 sel", 32'(sel), 0);
        chk("R6 rdata", 32'(rdata), 0);
        chk("R6 wait", 32'(wait_req), 0);
        put(16'hFFFF, 0, 1, 0);
        chk("R6 wr_en", 32'(wr_en), 0);
        chk("R6 addr out", 32'(xmem_addr), 0);
    endtask

    task automatic t_io_form();
        put(16'h0000, 1, 0, 1);
        chk("R7 io 00 sel", 32'(sel), 32'h02);
        chk("R7 io 00 idx", 32'(sio_idx), 0);
        chk("R8 io 00 bit", 32'(bit_ok), 1);
        chk("R11 rdata sio", 32'(rdata), 32'hB2);
        put(16'h001F, 0, 1, 1);
        chk("R7 io 1F idx", 32'(sio_idx), 31);
        chk("R8 io 1F bit", 32'(bit_ok), 1);
        put(16'h0020, 1, 0, 1);
        chk("R7 io 20 idx", 32'(sio_idx), 32);
        chk("R8 io 20 no bit", 32'(bit_ok), 0);
        put(16'h003F, 1, 0, 1);
        chk("R7 io 3F idx", 32'(sio_idx), 63);
        put(16'h0040, 1, 0, 1);
        chk("R7 io 40 sel", 32'(sel), 0);
        chk("R7 io 40 rdata", 32'(rdata), 0);
        chk("R8 io 40 bit", 32'(bit_ok), 0);
    endtask

    task automatic t_idle();
        put(16'h0100, 0, 0, 0);
        chk("R10 idle sel", 32'(sel), 0);
        chk("R10 idle off", 32'(sram_off), 0);
        put(16'h0005, 0, 0, 1);
        chk("R10 idle bit", 32'(bit_ok), 0);
    endtask

    task automatic t_reset_wait();
        xmem_en = 1'b1;
        put(16'h2000, 1, 0, 0);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12 wait after reset", 32'(wait_req), 1);
        @(negedge clk); #1;
        chk("R12 second after reset", 32'(wait_req), 0);
        idle();
        xmem_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regfile();
        t_stdio();
        t_extio();
        t_sram();
        t_xmem_on();
        t_xmem_off();
        t_io_form();
        t_idle();
        t_reset_wait();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule